// File: doc/BRIEF.md
# Transmit Request Channel Controller

This block sequences one transmit channel. It takes request objects from a request queue, has the frame sent, and writes one confirmation status code for each object it consumes. The frame data path and the bus master sit outside the block. Each is modelled here by a simple strobe and acknowledge pair: fetch, send and confirmation write.

While an object is being worked on, the block watches four inputs: the ring-operational level, a FIFO underrun flag, a MAC reset and a bus error. A fault ends work on the current object and records its cause in the confirmation code. It also raises one-cycle attention pulses toward the host's attention register bank. The outcome depends on the fault:

- A lost ring flushes only the current object. The channel then parks until the host clears the unserviceable condition, and it resumes with the objects that are still queued.
- A bus error stops the channel for good, until the block is reset.
- A full confirmation queue holds the channel until a slot frees up.

Top module: `tx_req_channel`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, every output is 0.
- R2: Normal sequence:
  - From idle, with `req_avail` and `ring_op` both high, `req_rd` rises in the next cycle and stays high until `req_ack`.
  - `tx_go` is then high from the next cycle until `tx_done`.
  - `cnf_wr` is then high with `cnf_code` = 0. At most one of `req_rd`, `tx_go` and `cnf_wr` is high at a time.
  - `req_pop` is high in the cycle where `cnf_wr` and `cnf_ack` are both high and `bus_err` is low.
  - After a successful confirmation the block returns to idle.
- R3: Ring loss:
  - If `ring_op` is low during fetch or send, the object is flushed. It is confirmed with code 2 and popped, and `usr_att` pulses for one cycle, in the cycle after the fault.
  - Ring loss during send also pulses `exc_att`.
  - After that confirmation the channel starts no fetch, whatever `req_avail` is, until `usr_clear` is seen. It then returns to idle and serves the queued objects.
- R4: `fifo_underrun` during send confirms code 1 and pulses `exc_att`. The channel then continues normally. During fetch, `fifo_underrun` is ignored.
- R5: `mac_reset` during fetch or send confirms code 3 and pulses `exc_att`.
- R6: A bus error during fetch or send pulses `exc_att` and `err_att`. The object is confirmed with code 4, and after that confirmation the channel stops.
- R7: A bus error while confirming stops the channel at once:
  - `exc_att` and `err_att` pulse, and `req_pop` stays low.
  - `chan_stopped` is high from the next cycle.
  - Once stopped, the channel stays stopped with `req_rd`, `tx_go` and `cnf_wr` low until reset.
- R8: When several causes occur in the same cycle, the order is bus error, then MAC reset, then ring loss, then underrun. Any fault takes precedence over a `req_ack` or `tx_done` in the same cycle.
- R9: Confirmation queue full:
  - `cnf_wr` is never high while `cnf_full` is high.
  - `cnf_full` during confirmation parks the channel and pulses `nsp_att` once.
  - When `cnf_full` falls, the same code is written.
- R10: While idle with `ring_op` low, no fetch starts and no attention is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_avail | input | 1 | Request queue holds at least one object |
| req_ack | input | 1 | Request object fetch complete |
| ring_op | input | 1 | Ring operational level |
| fifo_underrun | input | 1 | Transmit FIFO underrun flag |
| mac_reset | input | 1 | MAC reset indication |
| bus_err | input | 1 | Bus error on the current access |
| tx_done | input | 1 | Frame transmission complete |
| cnf_full | input | 1 | Confirmation status queue is full |
| cnf_ack | input | 1 | Confirmation write accepted |
| usr_clear | input | 1 | Host cleared the unserviceable attention |
| req_rd | output | 1 | Fetch strobe for the head request object |
| tx_go | output | 1 | Transmit strobe for the fetched object |
| cnf_wr | output | 1 | Confirmation write strobe |
| cnf_code | output | 3 | Confirmation cause: 0 ok, 1 underrun, 2 ring lost, 3 MAC reset, 4 bus error |
| req_pop | output | 1 | Current object consumed from the request queue |
| exc_att | output | 1 | Exception attention pulse |
| usr_att | output | 1 | Unserviceable attention pulse |
| err_att | output | 1 | Global error attention pulse |
| nsp_att | output | 1 | No confirmation space attention pulse |
| chan_stopped | output | 1 | Channel stopped until reset |

## Verification
The properties assume the following about the inputs:
- Every input is synchronous and settled at the clock edge.
- `bus_err` refers to whichever access strobe is currently active.
- Reset is held for at least one clock edge before any past-value property is evaluated.

The bench meets these assumptions as follows. It changes inputs only at the falling edge. It holds reset for several edges. It keeps faults rare and random, so that the channel passes through every state. Once the channel has stopped, it resets it again so the run can continue. Directed cases place faults at chosen states.

// File: rtl/tx_chan_pkg.sv
// Shared types of the transmit request channel: states, confirmation causes,
// the fault record passed from the arbiter to the sequencer, and the indices
// of the attention pulse vector.
package tx_chan_pkg;

    localparam int CAUSE_W = 3;
    localparam int N_ATT   = 4;
    localparam int ATT_EXC = 0;
    localparam int ATT_USR = 1;
    localparam int ATT_ERR = 2;
    localparam int ATT_NSP = 3;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_FETCH    = 3'd1,
        ST_SEND     = 3'd2,
        ST_CONFIRM  = 3'd3,
        ST_PARK_USR = 3'd4,
        ST_PARK_NSP = 3'd5,
        ST_STOPPED  = 3'd6
    } chan_state_e;

    typedef enum logic [CAUSE_W-1:0] {
        CC_OK        = 3'd0,
        CC_UNDERRUN  = 3'd1,
        CC_RING_LOST = 3'd2,
        CC_MAC_RESET = 3'd3,
        CC_BUS_ERR   = 3'd4
    } cnf_cause_e;

    typedef struct packed {
        logic       hit;
        cnf_cause_e cause;
        logic       exc;
        logic       usr;
        logic       err;
    } fault_t;

endpackage

// File: rtl/tx_fault_arbiter.sv
// Priority selection among the fault inputs while an object is being fetched
// or sent. The order is bus error, MAC reset, ring loss, then underrun.
// Assumes: underrun is meaningful only during send. Outside fetch and send,
// no fault is reported.
module tx_fault_arbiter
    import tx_chan_pkg::*;
(
    input  logic   in_fetch,
    input  logic   in_send,
    input  logic   bus_err,
    input  logic   mac_reset,
    input  logic   ring_op,
    input  logic   fifo_underrun,
    output fault_t fault
);

    // Picks the highest-priority cause and the attentions it raises.
    always_comb begin
        fault       = '0;
        fault.cause = CC_OK;
        if (bus_err) begin
            fault.hit   = 1'b1;
            fault.cause = CC_BUS_ERR;
            fault.exc   = 1'b1;
            fault.err   = 1'b1;
        end else if (mac_reset) begin
            fault.hit   = 1'b1;
            fault.cause = CC_MAC_RESET;
            fault.exc   = 1'b1;
        end else if (!ring_op) begin
            fault.hit   = 1'b1;
            fault.cause = CC_RING_LOST;
            fault.usr   = 1'b1;
            fault.exc   = in_send;
        end else if (in_send && fifo_underrun) begin
            fault.hit   = 1'b1;
            fault.cause = CC_UNDERRUN;
            fault.exc   = 1'b1;
        end
        if (!(in_fetch || in_send)) begin
            fault     = '0;
            fault.cause = CC_OK;
        end
    end

endmodule

// File: rtl/tx_chan_fsm.sv
// Channel sequencer: holds the state and the recorded confirmation cause.
// It decides the next step from the handshakes and the arbitrated fault, and
// emits one-cycle attention requests on the transitions that raise them.
// Assumes: handshake inputs are synchronous to clk.
module tx_chan_fsm
    import tx_chan_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_avail,
    input  logic               ring_op,
    input  logic               req_ack,
    input  logic               tx_done,
    input  logic               cnf_full,
    input  logic               cnf_ack,
    input  logic               usr_clear,
    input  logic               bus_err,
    input  fault_t             fault,
    output chan_state_e        state,
    output cnf_cause_e         cause,
    output logic [N_ATT-1:0]   att_set
);

    chan_state_e state_nx;
    cnf_cause_e  cause_nx;

    // Next state, next cause and attention requests.
    always_comb begin
        state_nx = state;
        cause_nx = cause;
        att_set  = '0;
        case (state)
            ST_IDLE: begin
                if (req_avail && ring_op) state_nx = ST_FETCH;
            end
            ST_FETCH, ST_SEND: begin
                if (fault.hit) begin
                    state_nx         = ST_CONFIRM;
                    cause_nx         = fault.cause;
                    att_set[ATT_EXC] = fault.exc;
                    att_set[ATT_USR] = fault.usr;
                    att_set[ATT_ERR] = fault.err;
                end else if (state == ST_FETCH && req_ack) begin
                    state_nx = ST_SEND;
                end else if (state == ST_SEND && tx_done) begin
                    state_nx = ST_CONFIRM;
                    cause_nx = CC_OK;
                end
            end
            ST_CONFIRM: begin
                if (bus_err) begin
                    state_nx         = ST_STOPPED;
                    att_set[ATT_EXC] = 1'b1;
                    att_set[ATT_ERR] = 1'b1;
                end else if (cnf_full) begin
                    state_nx         = ST_PARK_NSP;
                    att_set[ATT_NSP] = 1'b1;
                end else if (cnf_ack) begin
                    case (cause)
                        CC_BUS_ERR:   state_nx = ST_STOPPED;
                        CC_RING_LOST: state_nx = ST_PARK_USR;
                        default:      state_nx = ST_IDLE;
                    endcase
                end
            end
            ST_PARK_NSP: begin
                if (!cnf_full) state_nx = ST_CONFIRM;
            end
            ST_PARK_USR: begin
                if (usr_clear) state_nx = ST_IDLE;
            end
            ST_STOPPED: state_nx = ST_STOPPED;
            default:    state_nx = ST_STOPPED;
        endcase
    end

    // State and cause registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cause <= CC_OK;
        end else begin
            state <= state_nx;
            cause <= cause_nx;
        end
    end

endmodule

// File: rtl/tx_att_pulse.sv
// Registers each attention request into a one-cycle pulse toward the
// attention register bank. Assumes: requests are one cycle wide already.
module tx_att_pulse #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    output logic [N-1:0] pulse
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        // One flop per attention line.
        always_ff @(posedge clk) begin
            if (!rst_n) pulse[i] <= 1'b0;
            else        pulse[i] <= set[i];
        end
    end

endmodule

// File: rtl/tx_req_channel.sv
// Transmit request channel controller top. It ties the fault arbiter, the
// sequencer and the attention pulse stage together, and decodes the access
// strobes from the state.
// Assumes: all inputs are synchronous, and bus_err relates to the active
// strobe.
module tx_req_channel
    import tx_chan_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_avail,
    input  logic               req_ack,
    input  logic               ring_op,
    input  logic               fifo_underrun,
    input  logic               mac_reset,
    input  logic               bus_err,
    input  logic               tx_done,
    input  logic               cnf_full,
    input  logic               cnf_ack,
    input  logic               usr_clear,
    output logic               req_rd,
    output logic               tx_go,
    output logic               cnf_wr,
    output logic [CAUSE_W-1:0] cnf_code,
    output logic               req_pop,
    output logic               exc_att,
    output logic               usr_att,
    output logic               err_att,
    output logic               nsp_att,
    output logic               chan_stopped
);

    chan_state_e      state;
    cnf_cause_e       cause;
    fault_t           fault;
    logic [N_ATT-1:0] att_set;
    logic [N_ATT-1:0] att_q;

    tx_fault_arbiter u_arb (
        .in_fetch      (state == ST_FETCH),
        .in_send       (state == ST_SEND),
        .bus_err       (bus_err),
        .mac_reset     (mac_reset),
        .ring_op       (ring_op),
        .fifo_underrun (fifo_underrun),
        .fault         (fault)
    );

    tx_chan_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_avail (req_avail),
        .ring_op   (ring_op),
        .req_ack   (req_ack),
        .tx_done   (tx_done),
        .cnf_full  (cnf_full),
        .cnf_ack   (cnf_ack),
        .usr_clear (usr_clear),
        .bus_err   (bus_err),
        .fault     (fault),
        .state     (state),
        .cause     (cause),
        .att_set   (att_set)
    );

    tx_att_pulse #(.N(N_ATT)) u_att (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (att_set),
        .pulse (att_q)
    );

    // Access strobes and status decoded from the sequencer state.
    always_comb begin
        req_rd       = (state == ST_FETCH);
        tx_go        = (state == ST_SEND);
        cnf_wr       = (state == ST_CONFIRM) && !cnf_full;
        cnf_code     = cause;
        req_pop      = cnf_wr && cnf_ack && !bus_err;
        chan_stopped = (state == ST_STOPPED);
        exc_att      = att_q[ATT_EXC];
        usr_att      = att_q[ATT_USR];
        err_att      = att_q[ATT_ERR];
        nsp_att      = att_q[ATT_NSP];
    end

endmodule

// File: rtl/tx_req_channel_chk.sv
// Property checker for the transmit request channel, bound to the top module.
module tx_req_channel_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_err,
    input logic       mac_reset,
    input logic       cnf_full,
    input logic       req_rd,
    input logic       tx_go,
    input logic       cnf_wr,
    input logic [2:0] cnf_code,
    input logic       exc_att,
    input logic       usr_att,
    input logic       err_att,
    input logic       nsp_att,
    input logic       chan_stopped
);

    assert_one_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_rd, tx_go, cnf_wr}));

    assert_usr_parks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        usr_att |-> !req_rd && !tx_go);

    assert_code_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnf_wr |-> cnf_code <= 3'd4);

    assert_mac_reset_exc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_go && mac_reset && !bus_err) |=> exc_att && !err_att);

    assert_err_with_exc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err_att |-> exc_att);

    assert_stop_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        chan_stopped |=> chan_stopped);

    assert_stop_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        chan_stopped |-> !req_rd && !tx_go && !cnf_wr);

    assert_bus_err_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_rd || tx_go) && bus_err) |=> err_att);

    assert_nospace_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        nsp_att |-> !cnf_wr);

    assert_full_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cnf_full |-> !cnf_wr);

endmodule

bind tx_req_channel tx_req_channel_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_err      (bus_err),
    .mac_reset    (mac_reset),
    .cnf_full     (cnf_full),
    .req_rd       (req_rd),
    .tx_go        (tx_go),
    .cnf_wr       (cnf_wr),
    .cnf_code     (cnf_code),
    .exc_att      (exc_att),
    .usr_att      (usr_att),
    .err_att      (err_att),
    .nsp_att      (nsp_att),
    .chan_stopped (chan_stopped)
);

// File: tb/tx_req_channel_tb.sv
module tx_req_channel_tb;

    localparam int CLK_P = 10;
    localparam int S_IDLE = 0, S_FETCH = 1, S_SEND = 2, S_CONF = 3;
    localparam int S_PU = 4, S_PN = 5, S_STOP = 6;

    logic clk = 1'b0;
    always #(CLK_P/2) clk = ~clk;

    logic rst_n, req_avail, req_ack, ring_op, fifo_underrun, mac_reset;
    logic bus_err, tx_done, cnf_full, cnf_ack, usr_clear;
    logic req_rd, tx_go, cnf_wr, req_pop, exc_att, usr_att, err_att, nsp_att, chan_stopped;
    logic [2:0] cnf_code;

    tx_req_channel u_dut (.*);

    int    n_chk = 0, n_fail = 0;
    bit    done = 0;
    string phase = "R1";
    int    ms, mc;
    bit    e_exc, e_usr, e_err, e_nsp;

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL [%s] %s: actual %0d expected %0d", phase, tag, act, exp);
        end
    endtask

    function automatic string code_tag(int c);
        case (c)
            0:       return "R2 cnf_code";
            1:       return "R4 cnf_code";
            2:       return "R3 cnf_code";
            3:       return "R5 cnf_code";
            default: return "R6 cnf_code";
        endcase
    endfunction

    task automatic check_outputs();
        bit ecw;
        ecw = (ms == S_CONF) && !cnf_full;
        chk("R2 req_rd", {7'd0, req_rd}, {7'd0, ms == S_FETCH});
        chk("R2 tx_go", {7'd0, tx_go}, {7'd0, ms == S_SEND});
        chk("R9 cnf_wr", {7'd0, cnf_wr}, {7'd0, ecw});
        if (ecw) chk(code_tag(mc), {5'd0, cnf_code}, mc[7:0]);
        chk("R2 req_pop", {7'd0, req_pop}, {7'd0, ecw && cnf_ack && !bus_err});
        chk("R4 exc_att", {7'd0, exc_att}, {7'd0, e_exc});
        chk("R3 usr_att", {7'd0, usr_att}, {7'd0, e_usr});
        chk("R6 err_att", {7'd0, err_att}, {7'd0, e_err});
        chk("R9 nsp_att", {7'd0, nsp_att}, {7'd0, e_nsp});
        chk("R7 chan_stopped", {7'd0, chan_stopped}, {7'd0, ms == S_STOP});
    endtask

    // Expected behaviour, derived from the requirements and applied at each edge.
    task automatic model_step();
        bit x, u, r;
        x = 0; u = 0; r = 0;
        e_nsp = 0;
        if (!rst_n) begin
            ms = S_IDLE; mc = 0;
        end else begin
            case (ms)
                S_IDLE: if (req_avail && ring_op) ms = S_FETCH;
                S_FETCH, S_SEND: begin
                    if (bus_err) begin
                        mc = 4; x = 1; r = 1; ms = S_CONF;
                    end else if (mac_reset) begin
                        mc = 3; x = 1; ms = S_CONF;
                    end else if (!ring_op) begin
                        mc = 2; u = 1; x = (ms == S_SEND); ms = S_CONF;
                    end else if (ms == S_SEND && fifo_underrun) begin
                        mc = 1; x = 1; ms = S_CONF;
                    end else if (ms == S_FETCH && req_ack) begin
                        ms = S_SEND;
                    end else if (ms == S_SEND && tx_done) begin
                        mc = 0; ms = S_CONF;
                    end
                end
                S_CONF: begin
                    if (bus_err) begin
                        x = 1; r = 1; ms = S_STOP;
                    end else if (cnf_full) begin
                        e_nsp = 1; ms = S_PN;
                    end else if (cnf_ack) begin
                        ms = (mc == 4) ? S_STOP : (mc == 2) ? S_PU : S_IDLE;
                    end
                end
                S_PN: if (!cnf_full) ms = S_CONF;
                S_PU: if (usr_clear) ms = S_IDLE;
                default: ;
            endcase
        end
        e_exc = x; e_usr = u; e_err = r;
    endtask

    // One clock: check before the rising edge, update the model, return at the falling edge.
    task automatic cyc(int n = 1);
        for (int i = 0; i < n; i++) begin
            #(CLK_P/2 - 1);
            check_outputs();
            @(posedge clk);
            model_step();
            @(negedge clk);
        end
    endtask

    task automatic wait_state(int s);
        for (int i = 0; i < 30 && ms != s; i++) cyc();
    endtask

    task automatic quiet();
        req_avail = 0; req_ack = 0; ring_op = 1; fifo_underrun = 0; mac_reset = 0;
        bus_err = 0; tx_done = 0; cnf_full = 0; cnf_ack = 0; usr_clear = 0;
    endtask

    task automatic do_reset();
        rst_n = 0;
        cyc(3);
        rst_n = 1;
        cyc();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        n_chk++; n_fail++;
        $display("FAIL [watchdog] run did not finish");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        quiet();
        rst_n = 0;
        ms = S_IDLE; mc = 0; e_exc = 0; e_usr = 0; e_err = 0; e_nsp = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        phase = "R1";
        do_reset();

        phase = "R2";
        req_avail = 1; req_ack = 1; tx_done = 1; cnf_ack = 1;
        cyc(12);

        phase = "R10";
        quiet(); do_reset();
        ring_op = 0; req_avail = 1;
        cyc(6);

        phase = "R3";
        ring_op = 1; req_ack = 1; cnf_ack = 1;
        wait_state(S_SEND); cyc(2);
        ring_op = 0; cyc();
        ring_op = 1; cyc(6);
        usr_clear = 1; cyc(); usr_clear = 0;
        tx_done = 1; cyc(6); tx_done = 0;

        phase = "R4";
        wait_state(S_SEND);
        fifo_underrun = 1; cyc(); fifo_underrun = 0; cyc(4);

        phase = "R9";
        tx_done = 1; cnf_full = 1;
        wait_state(S_PN); cyc(3);
        cnf_full = 0; cyc(4); tx_done = 0;

        phase = "R5";
        wait_state(S_FETCH);
        mac_reset = 1; cyc(); mac_reset = 0; cyc(5);

        phase = "R8";
        wait_state(S_SEND);
        bus_err = 1; mac_reset = 1; ring_op = 0; fifo_underrun = 1; cyc();
        quiet(); req_avail = 1; req_ack = 1; cnf_ack = 1; cyc(6);

        phase = "R7";
        quiet(); do_reset();
        req_avail = 1; req_ack = 1; tx_done = 1;
        wait_state(S_CONF);
        bus_err = 1; cnf_ack = 1; cyc(); bus_err = 0; cyc(5);

        phase = "R6";
        quiet(); do_reset();
        req_avail = 1;
        wait_state(S_FETCH);
        bus_err = 1; cyc(); bus_err = 0; cnf_ack = 1; cyc(5);

        phase = "random";
        quiet(); do_reset();
        for (int k = 0; k < 6000; k++) begin
            req_avail     = ($urandom % 4) != 0;
            ring_op       = ($urandom % 40) != 0;
            req_ack       = ($urandom % 3) == 0;
            tx_done       = ($urandom % 4) == 0;
            cnf_ack       = ($urandom % 2) == 0;
            cnf_full      = ($urandom % 10) == 0;
            fifo_underrun = ($urandom % 30) == 0;
            mac_reset     = ($urandom % 50) == 0;
            bus_err       = ($urandom % 300) == 0;
            usr_clear     = ($urandom % 8) == 0;
            cyc();
            if (ms == S_STOP) begin
                quiet(); cyc(2); do_reset();
            end
        end
        finish_run();
    end

endmodule